// File: doc/BRIEF.md
# Programmable Down-Counter Channel with Six Gate Modes

This block is one channel of a programmable interval timer. A 16-bit down-counter runs on the count clock. A gate input controls it, and a single waveform output reports its state. A host interface outside the block decodes bus writes and stores the control word. It gives the channel three things: a mode-set strobe with the mode code and the decimal-count select, a strobe for the full count value, and a strobe that marks a first count byte still waiting for its partner byte. The live count is always visible for readback.

The mode code selects one of six behaviours:

- **Mode 0:** terminal-count flag.
- **Mode 1:** gate-triggered one-shot.
- **Mode 2:** rate divider.
- **Mode 3:** square wave.
- **Mode 4:** strobe started by a count write.
- **Mode 5:** strobe started by the gate.

The modes differ in three ways: whether a count write or a gate rising edge starts counting, whether a low gate pauses counting, and when a count written during counting takes effect. The counter can count down in plain binary or as four BCD digits.

All inputs are sampled on the rising edge of `clk`. A write or trigger sampled at an edge takes effect in that edge: after it, `count` shows the new value and `out` shows its new level. A gate rising edge is detected by comparing `gate` with its value at the previous edge.

Top module: `pit_counter_channel`

## Requirements
- R1: After reset the counter reads 0 and `out` is low. A mode-set strobe clears the counter to 0 and disarms the channel: it then holds 0 until a count is written. The mode-set strobe drives `out` low for mode code 0 and high for mode codes 1 to 5.
- R2: Mode 0. The count write sets `count` to n and `out` low in the edge that samples it. Counting then goes down by one per edge. `out` rises at the n-th edge after the write and stays high until the channel is reprogrammed.
- R3: Mode 0. While `gate` is low, the count holds. A first-byte strobe (`load_lsb`) freezes the count from the edge that samples it onward. The next full count write restarts counting from the new value, as in R2.
- R4: Mode 1. A count write alone changes neither `count` nor `out`. A gate rising edge loads n and drives `out` low. `out` returns high at the n-th edge after the trigger. A low gate during this time does not stop the count.
- R5: Mode 2. `out` is low for exactly one clock at edge n-1, 2n-1, 3n-1 and so on, counted from the load. The count runs n, n-1, down to 1, then reloads n. A count written while counting takes effect only when the current period ends.
- R6: Modes 2 and 3. A low gate forces `out` high at the next edge and holds the count. The next gate rising edge reloads the stored count with `out` high.
- R7: Mode 3. The counter steps down by 2 and always holds an even value. `out` is high for (n+1)/2 clocks and low for n/2 clocks, with the division rounding down. The period is n.
- R8: Mode 4. A count write loads n with `out` high. `out` is low for one clock only, at the n-th edge after the write, and the pulse does not repeat. A low gate holds the count. A gate rising edge reloads the stored count.
- R9: Mode 5. A gate rising edge loads n. `out` is low for one clock at the n-th edge after the most recent trigger. A new rising edge during counting restarts the count from n.
- R10: A count value of 0 counts 65536 clocks in binary and 10000 clocks in decimal. The first decrement from 0 reads 0xFFFF in binary and 0x9999 in decimal.
- R11: With the decimal-count select at 1, each nibble holds one decimal digit and the count steps down digit-wise with borrow, for example 0x0100 to 0x0099.
- R12: Mode codes 6 and 7 act exactly like mode codes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode-set strobe |
| mode_sel | input | 3 | Mode code used with `mode_wr` |
| bcd_sel | input | 1 | 1 selects four-digit decimal counting; used with `mode_wr` |
| load_wr | input | 1 | Full count value written |
| load_lsb | input | 1 | First byte of a two-byte count written (mode 0 freeze) |
| load_val | input | 16 | Count value used with `load_wr` |
| gate | input | 1 | Gate input |
| out | output | 1 | Waveform output |
| count | output | 16 | Live counter value |

## Verification
Every result appears at a fixed edge counted from the edge that sampled its cause. A load or trigger shows its value at that same edge. Mode 0 and mode 4 respond at the n-th following edge, mode 2 pulses at edge n-1 of each period, and a gate-low response appears one edge later. The bench drives and samples only on falling edges. It keeps an edge index j that starts at 0 on the load or trigger edge, and it compares `out` and `count` at each j against closed-form functions of n and j. Tests that pause, rewrite or retrigger the channel restart or shift j by the known number of held edges.

// File: rtl/pit_counter_channel.sv
`timescale 1ns/1ps
module pit_counter_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_wr,
  input  logic [2:0]   mode_sel,
  input  logic         bcd_sel,
  input  logic         load_wr,
  input  logic         load_lsb,
  input  logic [W-1:0] load_val,
  input  logic         gate,
  output logic         out,
  output logic [W-1:0] count
);

  localparam int DIGITS = W / 4;
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  typedef enum logic [2:0] {
    M_TERM = 3'd0, M_ONESHOT = 3'd1, M_RATE = 3'd2,
    M_SQUARE = 3'd3, M_SWSTROBE = 3'd4, M_HWSTROBE = 3'd5
  } mode_t;

  function automatic logic [W-1:0] down1(input logic [W-1:0] v, input logic dec);
    logic [W-1:0] r;
    logic b;
    if (!dec) return v - ONE;
    r = v;
    b = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (b) begin
        if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
        else begin
          r[4*i +: 4] = v[4*i +: 4] - 4'd1;
          b = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic digits_ok(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  mode_t        mode_q, mode_d;
  logic         bcd_q, bcd_d;
  logic [W-1:0] cnt_q, cnt_d, reload_q, reload_d;
  logic         out_q, out_d, armed_q, armed_d, run_q, run_d;
  logic         halt_q, halt_d, fired_q, fired_d, odd_q, odd_d, gprev_q;

  wire          gate_rise  = gate & ~gprev_q;
  wire [W-1:0]  step1      = down1(cnt_q, bcd_q);
  wire [W-1:0]  step2      = down1(step1, bcd_q);
  wire [W-1:0]  even_rel   = {reload_q[W-1:1], 1'b0};
  wire          at_one     = (cnt_q == ONE);
  wire          at_two     = (cnt_q == TWO);
  wire          sq_edge    = (out_q && odd_q) ? (cnt_q == '0) : at_two;
  wire [2:0]    mode_code  = mode_sel[1] ? {1'b0, mode_sel[1:0]} : mode_sel;

  always_comb begin
    mode_d   = mode_q;   bcd_d   = bcd_q;
    cnt_d    = cnt_q;    reload_d = reload_q;
    out_d    = out_q;    armed_d = armed_q;
    run_d    = run_q;    halt_d  = halt_q;
    fired_d  = fired_q;  odd_d   = odd_q;
    if (mode_wr) begin
      mode_d  = mode_t'(mode_code);
      bcd_d   = bcd_sel;
      cnt_d   = '0;
      armed_d = 1'b0;
      run_d   = 1'b0;
      halt_d  = 1'b0;
      fired_d = 1'b0;
      odd_d   = 1'b0;
      out_d   = (mode_code != 3'd0);
    end else begin
      case (mode_q)
        M_TERM: begin
          if (load_wr) begin
            cnt_d    = load_val;
            reload_d = load_val;
            out_d    = 1'b0;
            armed_d  = 1'b1;
            halt_d   = 1'b0;
          end else begin
            if (load_lsb) halt_d = 1'b1;
            if (armed_q && gate && !halt_q && !load_lsb) begin
              cnt_d = step1;
              if (at_one) out_d = 1'b1;
            end
          end
        end
        M_SWSTROBE: begin
          if (load_wr) begin
            cnt_d    = load_val;
            reload_d = load_val;
            out_d    = 1'b1;
            armed_d  = 1'b1;
            fired_d  = 1'b0;
          end else begin
            if (!out_q) out_d = 1'b1;
            if (armed_q && gate_rise) begin
              cnt_d   = reload_q;
              fired_d = 1'b0;
            end else if (armed_q && gate) begin
              cnt_d = step1;
              if (at_one && !fired_q) begin
                out_d   = 1'b0;
                fired_d = 1'b1;
              end
            end
          end
        end
        M_ONESHOT, M_HWSTROBE: begin
          if (load_wr) begin
            reload_d = load_val;
            armed_d  = 1'b1;
          end
          if (mode_q == M_HWSTROBE && !out_q) out_d = 1'b1;
          if (gate_rise && armed_q) begin
            cnt_d   = reload_q;
            run_d   = 1'b1;
            fired_d = 1'b0;
            out_d   = (mode_q == M_HWSTROBE);
          end else if (run_q) begin
            cnt_d = step1;
            if (at_one) begin
              if (mode_q == M_ONESHOT) out_d = 1'b1;
              else if (!fired_q) begin
                out_d   = 1'b0;
                fired_d = 1'b1;
              end
            end
          end
        end
        M_RATE: begin
          if (load_wr) reload_d = load_val;
          if (load_wr && !armed_q) begin
            cnt_d   = load_val;
            armed_d = 1'b1;
            out_d   = 1'b1;
          end else if (armed_q) begin
            if (!gate) out_d = 1'b1;
            else if (gate_rise) begin
              cnt_d = reload_q;
              out_d = 1'b1;
            end else if (at_two) begin
              cnt_d = step1;
              out_d = 1'b0;
            end else if (at_one) begin
              cnt_d = reload_q;
              out_d = 1'b1;
            end else cnt_d = step1;
          end
        end
        M_SQUARE: begin
          if (load_wr) reload_d = load_val;
          if (load_wr && !armed_q) begin
            cnt_d   = {load_val[W-1:1], 1'b0};
            odd_d   = load_val[0];
            armed_d = 1'b1;
            out_d   = 1'b1;
          end else if (armed_q) begin
            if (!gate) out_d = 1'b1;
            else if (gate_rise) begin
              cnt_d = even_rel;
              odd_d = reload_q[0];
              out_d = 1'b1;
            end else if (sq_edge) begin
              cnt_d = even_rel;
              odd_d = reload_q[0];
              out_d = ~out_q;
            end else cnt_d = step2;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_TERM;
      bcd_q    <= 1'b0;
      cnt_q    <= '0;
      reload_q <= '0;
      out_q    <= 1'b0;
      armed_q  <= 1'b0;
      run_q    <= 1'b0;
      halt_q   <= 1'b0;
      fired_q  <= 1'b0;
      odd_q    <= 1'b0;
      gprev_q  <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      bcd_q    <= bcd_d;
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
      out_q    <= out_d;
      armed_q  <= armed_d;
      run_q    <= run_d;
      halt_q   <= halt_d;
      fired_q  <= fired_d;
      odd_q    <= odd_d;
      gprev_q  <= gate;
    end
  end

  assign out   = out_q;
  assign count = cnt_q;

  AST_TERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TERM && out_q && !mode_wr && !load_wr) |=> out) // R2
  ;
  AST_ONESHOT_IGNORES_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ONESHOT && run_q && !gate && !mode_wr) |=> (count != $past(count))) // R4
  ;
  AST_GATE_LOW_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_RATE || mode_q == M_SQUARE) && !gate && !mode_wr) |=> out) // R6
  ;
  AST_SQUARE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SQUARE && !mode_wr) |=> !count[0]) // R7
  ;
  AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_SWSTROBE || mode_q == M_HWSTROBE) && !out_q && !mode_wr) |=> out) // R8
  ;
  AST_DECIMAL_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd_q && !mode_wr && digits_ok(cnt_q) && digits_ok(reload_q) && digits_ok(load_val))
      |=> digits_ok(count)) // R11
  ;

endmodule

// File: tb/tb_pit_counter_channel.sv
`timescale 1ns/1ps
module tb_pit_counter_channel;
  logic        clk = 1'b0;
  logic        rst_n, mode_wr, bcd_sel, load_wr, load_lsb, gate;
  logic [2:0]  mode_sel;
  logic [15:0] load_val;
  logic        out;
  logic [15:0] count;
  int          errors = 0;
  int          checks = 0;

  always #2.5 clk = ~clk;

  pit_counter_channel dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .bcd_sel(bcd_sel), .load_wr(load_wr), .load_lsb(load_lsb),
    .load_val(load_val), .gate(gate), .out(out), .count(count)
  );

  task automatic check_eq(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic program_mode(input logic [2:0] m, input logic b);
    mode_sel = m; bcd_sel = b; mode_wr = 1'b1;
    step();
    mode_wr = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    load_val = v; load_wr = 1'b1;
    step();
    load_wr = 1'b0;
  endtask

  function automatic bit exp_out(input int m, input int n, input int j);
    case (m)
      0, 1:    return j >= n;
      2:       return (j % n) != (n - 1);
      3:       return (j % n) < (n + 1) / 2;
      default: return j != n;
    endcase
  endfunction

  function automatic int exp_cnt(input int m, input int n, input int j);
    if (m == 2) return n - (j % n);
    return n - j;
  endfunction

  task automatic run_pattern(input int m, input int n, input int len, input string req);
    for (int j = 0; j <= len; j++) begin
      check_eq(req, out, exp_out(m, n, j));
      if (m == 3) check_eq(req, count[0], 0);
      else if (m == 2 || j <= n) check_eq(req, count, exp_cnt(m, n, j));
      step();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7331);
    rst_n = 1'b0; mode_wr = 1'b0; bcd_sel = 1'b0; load_wr = 1'b0;
    load_lsb = 1'b0; gate = 1'b1; mode_sel = 3'd0; load_val = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset and mode set
    check_eq("R1 reset out", out, 0);
    check_eq("R1 reset count", count, 0);
    program_mode(3'd2, 1'b0);
    check_eq("R1 mode2 out", out, 1);
    repeat (3) step();
    check_eq("R1 unarmed count", count, 0);
    program_mode(3'd0, 1'b0);
    check_eq("R1 mode0 out", out, 0);

    // R2 mode 0 basic
    load(16'd7);
    run_pattern(0, 7, 10, "R2");

    // R3 gate pause
    program_mode(3'd0, 1'b0);
    load(16'd6);
    step(); step();
    gate = 1'b0;
    step(); step(); step();
    check_eq("R3 paused count", count, 4);
    check_eq("R3 paused out", out, 0);
    gate = 1'b1;
    step(); step(); step();
    check_eq("R3 resume j8 out", out, 0);
    step();
    check_eq("R3 resume j9 out", out, 1);

    // R3 first-byte freeze then new count
    program_mode(3'd0, 1'b0);
    load(16'd8);
    step(); step();
    load_lsb = 1'b1;
    step();
    load_lsb = 1'b0;
    check_eq("R3 frozen count", count, 6);
    step(); step();
    check_eq("R3 still frozen", count, 6);
    load(16'd5);
    run_pattern(0, 5, 7, "R3");

    // R4 one-shot
    gate = 1'b0;
    program_mode(3'd1, 1'b0);
    load(16'd4);
    repeat (3) step();
    check_eq("R4 no start out", out, 1);
    check_eq("R4 no start count", count, 0);
    gate = 1'b1;
    step();
    for (int j = 0; j <= 6; j++) begin
      check_eq("R4 out", out, j >= 4);
      if (j <= 4) check_eq("R4 count", count, 4 - j);
      if (j == 1) gate = 1'b0;
      step();
    end

    // R5 rate pattern and mid-count write
    gate = 1'b1;
    program_mode(3'd2, 1'b0);
    load(16'd4);
    run_pattern(2, 4, 12, "R5");
    program_mode(3'd2, 1'b0);
    load(16'd5);
    step(); step();
    load(16'd3);
    check_eq("R5 j3 count", count, 2);
    check_eq("R5 j3 out", out, 1);
    step();
    check_eq("R5 j4 out", out, 0);
    step();
    check_eq("R5 j5 count", count, 3);
    step();
    check_eq("R5 j6 out", out, 1);
    step();
    check_eq("R5 j7 out", out, 0);
    step();
    check_eq("R5 j8 count", count, 3);

    // R6 gate low in mode 2
    program_mode(3'd2, 1'b0);
    load(16'd5);
    step(); step();
    gate = 1'b0;
    step();
    check_eq("R6 forced out", out, 1);
    check_eq("R6 held count", count, 3);
    step(); step(); step();
    check_eq("R6 held later", count, 3);
    gate = 1'b1;
    step();
    run_pattern(2, 5, 11, "R6");

    // R7 square wave, even and odd
    program_mode(3'd3, 1'b0);
    load(16'd6);
    run_pattern(3, 6, 18, "R7");
    program_mode(3'd3, 1'b0);
    load(16'd7);
    run_pattern(3, 7, 21, "R7");
    program_mode(3'd3, 1'b0);
    load(16'd3);
    run_pattern(3, 3, 9, "R7");

    // R6 gate low in mode 3 during the low phase
    program_mode(3'd3, 1'b0);
    load(16'd8);
    repeat (5) step();
    check_eq("R6 sq low phase", out, 0);
    gate = 1'b0;
    step();
    check_eq("R6 sq forced out", out, 1);
    gate = 1'b1;
    step();
    run_pattern(3, 8, 10, "R6");

    // R8 software strobe and gate restart
    program_mode(3'd4, 1'b0);
    load(16'd5);
    run_pattern(4, 5, 14, "R8");
    program_mode(3'd4, 1'b0);
    load(16'd5);
    step(); step();
    gate = 1'b0;
    step(); step();
    check_eq("R8 held count", count, 3);
    gate = 1'b1;
    step();
    run_pattern(4, 5, 9, "R8");

    // R9 hardware strobe with retrigger
    gate = 1'b0;
    program_mode(3'd5, 1'b0);
    load(16'd6);
    gate = 1'b1;
    step();
    check_eq("R9 trigger count", count, 6);
    step(); step();
    gate = 1'b0;
    step();
    gate = 1'b1;
    step();
    run_pattern(5, 6, 9, "R9");

    // R12 alias codes
    program_mode(3'd6, 1'b0);
    load(16'd4);
    run_pattern(2, 4, 9, "R12");
    program_mode(3'd7, 1'b0);
    load(16'd5);
    run_pattern(3, 5, 10, "R12");

    // R11 decimal digits
    program_mode(3'd0, 1'b1);
    load(16'h0100);
    step();
    check_eq("R11 borrow", count, 16'h0099);
    program_mode(3'd0, 1'b1);
    load(16'h2000);
    step();
    check_eq("R11 borrow3", count, 16'h1999);
    program_mode(3'd3, 1'b1);
    load(16'h0010);
    run_pattern(3, 10, 25, "R11");

    // Random rounds across counting modes
    for (int k = 0; k < 12; k++) begin
      int m, n;
      case ($urandom % 4)
        0: m = 0;
        1: m = 2;
        2: m = 3;
        default: m = 4;
      endcase
      n = 2 + int'($urandom % 30);
      program_mode(3'(m), 1'b0);
      load(16'(n));
      case (m)
        0: run_pattern(m, n, 2 * n + 3, "R2");
        2: run_pattern(m, n, 2 * n + 3, "R5");
        3: run_pattern(m, n, 2 * n + 3, "R7");
        default: run_pattern(m, n, 2 * n + 3, "R8");
      endcase
    end

    // R10 maximum counts
    program_mode(3'd0, 1'b1);
    load(16'h0000);
    step();
    check_eq("R10 dec first", count, 16'h9999);
    repeat (9998) step();
    check_eq("R10 dec before", out, 0);
    step();
    check_eq("R10 dec at", out, 1);
    program_mode(3'd0, 1'b0);
    load(16'h0000);
    step();
    check_eq("R10 bin first", count, 16'hFFFF);
    repeat (65534) step();
    check_eq("R10 bin before", out, 0);
    step();
    check_eq("R10 bin at", out, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule